// File: doc/BRIEF.md
# Streaming Complex Gain Stage

This block scales a stream of complex samples by one real, signed gain. Each 32-bit input word packs a 16-bit signed real part above a 16-bit signed imaginary part. Each 64-bit output word packs the two 32-bit signed products the same way, with real above imaginary. Both components are multiplied by the same gain, so no cross terms are formed. A side packet marker (`in_last`) travels with each sample to the output, which keeps frame boundaries intact.

The input and output are valid/ready streams. A word moves on an edge where its valid and ready are both high. Once the output asserts valid, it holds its word and marker until the word is taken. The input is ready whenever the two-stage pipeline has room, or the output is being drained in the same cycle. With `out_ready` held high, the block accepts one sample per cycle.

The gain sits in a register behind a plain write/read port. The gain is copied into the pipeline together with each accepted sample. A later write therefore never alters a sample that is already in flight.

Top module: `cgain_stage`

## Requirements
- R1: The real component of an input word is `in_data[31:16]` and the imaginary component is `in_data[15:0]`, both signed two's complement.
- R2: `out_data[63:32]` holds the real product and `out_data[31:0]` holds the imaginary product, each the full signed 16x16 result in 32 bits.
- R3: Both components are multiplied by the same signed gain, with no cross terms between real and imaginary.
- R4: Reset clears all pipeline valid state (`out_valid` low) and sets the gain to 1.
- R5: A write with `cfg_addr` = 0 loads `cfg_wdata` into the gain. `cfg_rdata` returns the gain when `cfg_addr` = 0 and returns 0 at any other address. Writes to any other address leave the gain unchanged.
- R6: Each sample is scaled by the gain held at the edge where it is accepted. A write on that same edge applies only to later samples, and samples already in the pipeline keep their gain.
- R7: `out_last` on each output word equals the `in_last` that arrived with that sample.
- R8: With `out_ready` held high, a sample accepted at edge k is presented on the output after edge k+1, and `in_ready` stays high.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged. `in_ready` is high whenever `out_ready` is high. No sample is dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 32 | Real [31:16], imaginary [15:0] |
| in_last | input | 1 | Packet end marker of the input word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 64 | Real product [63:32], imaginary product [31:0] |
| out_last | output | 1 | Packet end marker of the output word |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |

## Verification
Two events can fall on the same clock edge. A gain write can coincide with a sample acceptance. A stalled output can coincide with a new input being offered. The bench forces the first case directly, writing a new gain on the very edge that accepts a sample. It also scatters writes at random through a stalled stream. Every output is then compared against products computed with the gain the bench recorded before applying that edge's write. The second case is judged by checking that a held output word stays the same across each stalled edge, and that the queue of expected samples drains exactly, with nothing missing or extra.

// File: rtl/cgain_pkg.sv
`timescale 1ns/1ps
package cgain_pkg;
  localparam int CMP_W = 16;
  localparam int GN_W  = 16;
  localparam int PRD_W = CMP_W + GN_W;
  localparam int LANES = 2;

  typedef logic signed [CMP_W-1:0] cmp_t;
  typedef logic signed [GN_W-1:0]  gain_t;
  typedef logic signed [PRD_W-1:0] prd_t;

  // Sample captured at acceptance, with the gain that applies to it
  typedef struct packed {
    cmp_t  re;
    cmp_t  im;
    gain_t gain;
    logic  last;
  } capt_t;

  typedef struct packed {
    prd_t re;
    prd_t im;
    logic last;
  } prod_t;
endpackage

// File: rtl/cgain_pipe_reg.sv
`timescale 1ns/1ps
module cgain_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign up_ready = !vld_q || dn_ready;
  assign dn_valid = vld_q;
  assign dn_data  = dat_q;

  always_ff @(posedge clk) begin
    if (rst)           vld_q <= 1'b0;
    else if (up_ready) vld_q <= up_valid;
  end

  always_ff @(posedge clk) begin
    if (up_ready && up_valid) dat_q <= up_data;
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));

  // R4
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> !dn_valid);
endmodule

// File: rtl/cgain_regs.sv
`timescale 1ns/1ps
module cgain_regs
  import cgain_pkg::*;
#(
  parameter int    ADDR_W    = 4,
  parameter int    GAIN_ADDR = 0,
  parameter gain_t GAIN_RST  = 16'sd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [GN_W-1:0]   cfg_wdata,
  output logic [GN_W-1:0]   cfg_rdata,
  output gain_t             gain
);
  localparam logic [ADDR_W-1:0] HIT = ADDR_W'(GAIN_ADDR);

  gain_t gain_q;
  logic  hit;

  assign hit       = (cfg_addr == HIT);
  assign gain      = gain_q;
  assign cfg_rdata = hit ? gain_q : '0;

  always_ff @(posedge clk) begin
    if (rst)              gain_q <= GAIN_RST;
    else if (cfg_wr && hit) gain_q <= cfg_wdata;
  end

  // R4
  gain_default_chk: assert property (@(posedge clk)
    rst |=> gain_q == GAIN_RST);

  // R5
  gain_write_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && hit |=> gain_q == $past(cfg_wdata));

  // R5
  foreign_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_wr && hit) |=> $stable(gain_q));
endmodule

// File: rtl/cgain_mult.sv
`timescale 1ns/1ps
module cgain_mult
  import cgain_pkg::*;
(
  input  capt_t a,
  output prod_t p
);
  cmp_t lane_in  [LANES];
  prd_t lane_out [LANES];

  assign lane_in[0] = a.re;
  assign lane_in[1] = a.im;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_out[i] = prd_t'(lane_in[i]) * prd_t'(a.gain);
  end

  assign p.re   = lane_out[0];
  assign p.im   = lane_out[1];
  assign p.last = a.last;
endmodule

// File: rtl/cgain_stage.sv
`timescale 1ns/1ps
module cgain_stage
  import cgain_pkg::*;
#(
  parameter int    ADDR_W    = 4,
  parameter int    GAIN_ADDR = 0,
  parameter gain_t GAIN_RST  = 16'sd1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2*CMP_W-1:0]   in_data,
  input  logic                 in_last,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2*PRD_W-1:0]   out_data,
  output logic                 out_last,
  input  logic                 cfg_wr,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [GN_W-1:0]      cfg_wdata,
  output logic [GN_W-1:0]      cfg_rdata
);
  localparam int CW = $bits(capt_t);
  localparam int PW = $bits(prod_t);

  gain_t gain;
  capt_t cap_in, cap_q;
  prod_t prd_d, prd_q;
  logic  mid_valid, mid_ready;

  cgain_regs #(
    .ADDR_W(ADDR_W), .GAIN_ADDR(GAIN_ADDR), .GAIN_RST(GAIN_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .gain(gain)
  );

  assign cap_in.re   = in_data[2*CMP_W-1:CMP_W];
  assign cap_in.im   = in_data[CMP_W-1:0];
  assign cap_in.gain = gain;
  assign cap_in.last = in_last;

  cgain_pipe_reg #(.W(CW)) u_cap (
    .clk(clk), .rst(rst),
    .up_valid(in_valid), .up_ready(in_ready), .up_data(cap_in),
    .dn_valid(mid_valid), .dn_ready(mid_ready), .dn_data(cap_q)
  );

  cgain_mult u_mult (.a(cap_q), .p(prd_d));

  cgain_pipe_reg #(.W(PW)) u_prod (
    .clk(clk), .rst(rst),
    .up_valid(mid_valid), .up_ready(mid_ready), .up_data(prd_d),
    .dn_valid(out_valid), .dn_ready(out_ready), .dn_data(prd_q)
  );

  assign out_data = {prd_q.re, prd_q.im};
  assign out_last = prd_q.last;

  // R9
  drain_ready_chk: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready);

  // R7
  last_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(out_last));
endmodule

// File: tb/cgain_stage_bench.sv
`timescale 1ns/1ps
module cgain_stage_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        in_ready, out_valid, out_last;
  logic [63:0] out_data;
  logic [15:0] cfg_rdata;

  always #5 clk = ~clk;

  cgain_stage u_cgain_stage (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [63:0] exp_q[$];
  bit          last_q[$];
  int          stamp_q[$];
  logic [15:0] shadow = 16'd1;
  bit          hold_pend = 0, lat_mode = 0, acc = 0, done = 0;
  logic [63:0] hold_d;
  logic        hold_l;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [31:0] d, input logic [15:0] g);
    logic signed [31:0] re, im, gg, pr, pi;
    re = 32'($signed(d[31:16]));
    im = 32'($signed(d[15:0]));
    gg = 32'($signed(g));
    pr = re * gg;
    pi = im * gg;
    return {pr, pi};
  endfunction

  task automatic cycle(input logic v, input logic [31:0] d, input logic l,
                       input logic ordy, input logic wr, input logic [3:0] a,
                       input logic [15:0] wd);
    @(negedge clk);
    in_valid = v; in_data = d; in_last = l; out_ready = ordy;
    cfg_wr = wr; cfg_addr = a; cfg_wdata = wd;
    #1;
    if (hold_pend)
      check(out_valid === 1'b1 && out_data === hold_d && out_last === hold_l,
            "R9", "stalled word changed", out_data, hold_d);
    hold_pend = out_valid && !out_ready;
    hold_d = out_data; hold_l = out_last;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R9", "output word with nothing pending", out_data, 64'h0);
      end else begin
        logic [63:0] e;
        bit el;
        int st;
        e = exp_q.pop_front(); el = last_q.pop_front(); st = stamp_q.pop_front();
        check(out_data === e, "R1 R2 R3 R6", "product", out_data, e);
        check(out_last === el, "R7", "last marker", 64'(out_last), 64'(el));
        if (lat_mode)
          check(cyc - st == 2, "R8", "latency", 64'(cyc - st), 64'd2);
      end
    end
    acc = v && in_ready;
    if (acc) begin
      exp_q.push_back(model(d, shadow));
      last_q.push_back(l);
      stamp_q.push_back(cyc);
    end
    if (wr && a == 4'd0) shadow = wd;
    cyc++;
  endtask

  task automatic idle(input logic ordy);
    cycle(1'b0, 32'h0, 1'b0, ordy, 1'b0, 4'd0, 16'h0);
  endtask

  task automatic drain();
    for (int k = 0; k < 20 && exp_q.size() != 0; k++) idle(1'b1);
    idle(1'b1);
    check(exp_q.size() == 0, "R9", "samples left undelivered", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int cv[6];
    int gv[6];
    cv = '{-32768, -1, 0, 1, 32767, 12345};
    gv = '{1, -1, 0, 2, 32767, -32768};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R4 reset state
    check(out_valid === 1'b0, "R4", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready === 1'b1, "R4", "in_ready after reset", 64'(in_ready), 64'd1);
    check(cfg_rdata === 16'd1, "R4", "default gain", 64'(cfg_rdata), 64'd1);

    // R5 register port
    cycle(1'b0, 32'h0, 1'b0, 1'b1, 1'b1, 4'd3, 16'h1234);
    idle(1'b1);
    check(cfg_rdata === 16'd1, "R5", "foreign write touched gain", 64'(cfg_rdata), 64'd1);
    cycle(1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 4'd3, 16'h0);
    check(cfg_rdata === 16'd0, "R5", "foreign address read", 64'(cfg_rdata), 64'd0);
    cycle(1'b0, 32'h0, 1'b0, 1'b1, 1'b1, 4'd0, 16'hFFFD);
    idle(1'b1);
    check(cfg_rdata === 16'hFFFD, "R5", "gain readback", 64'(cfg_rdata), 64'hFFFD);

    // R8 throughput and latency with no stall
    lat_mode = 1;
    for (int i = 0; i < 10; i++) begin
      cycle(1'b1, {16'(i * 1000 - 3000), 16'(7 - i)}, 1'(i == 9), 1'b1, 1'b0, 4'd0, 16'h0);
      check(acc, "R8", "in_ready dropped without stall", 64'(acc), 64'd1);
    end
    drain();
    lat_mode = 0;

    // Sweep of component and gain corners under random stalls
    foreach (gv[gi]) begin
      cycle(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 4'd0, 16'(gv[gi]));
      for (int i = 0; i < 36; i++) begin
        logic [31:0] d;
        d = {16'(cv[i / 6]), 16'(cv[i % 6])};
        do begin
          cycle(($urandom % 10) < 7, d, 1'((i % 5) == 4), ($urandom % 10) < 6,
                1'b0, 4'd0, 16'h0);
        end while (!acc);
      end
    end
    drain();

    // R6 write on the very edge that accepts a sample
    idle(1'b1);
    cycle(1'b1, 32'h0003_FFFB, 1'b0, 1'b1, 1'b1, 4'd0, 16'd9);
    check(acc, "R6", "sample not taken alongside write", 64'(acc), 64'd1);
    cycle(1'b1, 32'h0003_FFFB, 1'b1, 1'b1, 1'b0, 4'd0, 16'h0);
    drain();

    // R6 random gain writes in a stalled stream
    for (int k = 0; k < 1500; k++) begin
      cycle(($urandom % 4) != 0, $urandom, ($urandom % 6) == 0, ($urandom % 3) != 0,
            ($urandom % 6) == 0, (($urandom % 4) == 0) ? 4'd5 : 4'd0, 16'($urandom));
    end
    drain();

    // R4 reset with samples in flight
    for (int k = 0; k < 4; k++)
      cycle(1'b1, 32'h0100_0200, 1'b0, 1'b0, 1'b1, 4'd0, 16'd4);
    @(negedge clk);
    in_valid = 1'b0; cfg_wr = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cfg_addr = 4'd0;
    #1;
    check(out_valid === 1'b0, "R4", "out_valid after mid-run reset", 64'(out_valid), 64'd0);
    check(cfg_rdata === 16'd1, "R4", "gain after mid-run reset", 64'(cfg_rdata), 64'd1);
    exp_q.delete(); last_q.delete(); stamp_q.delete();
    shadow = 16'd1; hold_pend = 0;
    cycle(1'b1, 32'h0005_FFF9, 1'b1, 1'b1, 1'b0, 4'd0, 16'h0);
    drain();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule